// File: doc/BRIEF.md
# Shift-Rotate Accumulator Register Unit

This block holds a 32-bit accumulator that a processor reaches through a byte-wide register bus. The processor loads the accumulator one byte at a time. It can then write a 4-bit move code to one of two command registers. One command shifts the accumulator in place. The other rotates it in place. Each operation finishes in the same clock edge that accepts the write.

A single code carries both the direction and the distance. When bit 3 of the code is set, the move is to the right by 8 minus code[2:0] places, which gives 1 to 8 places. When bit 3 is clear, the move is to the left by code[2:0] places, which gives 0 to 7 places. A code whose low nibble is zero does nothing.

The last code written to each command register reads back in full. The accumulator bytes also read back. Two fixed bytes at the top of the window give a version number and a signature.

Top module: `acc_shift_unit`

## Requirements
- R1: A write to index 0..3 loads accumulator byte 0..3 (index 0 holds bits 7:0, index 3 holds bits 31:24) and leaves the other bytes unchanged. Reading the same index returns that byte.
- R2: A write to index 4 (shift) or index 5 (rotate) stores all 8 bits of the code, and that code reads back at the same index.
- R3: A shift code with bit 3 clear moves the accumulator left by code[2:0] places. Bits shifted past bit 31 are lost, and zeros enter at the bottom.
- R4: A shift code with bit 3 set moves the accumulator right by 8 - code[2:0] places, with zeros entering at the top.
- R5: A rotate code uses the same direction and distance as R3 and R4, but bits that leave one end enter at the other.
- R6: A code whose bits 3:0 are zero, or a left move of zero places, leaves the accumulator unchanged. This holds for both commands.
- R7: Bits 7:4 of a command code do not affect the operation.
- R8: Reading index 0x1E returns 0x10 (version), and reading index 0x1F returns 0x51 (signature).
- R9: When rd_en is low, rdata is 0x00. Unmapped indices read as 0x00, and writes to them change nothing.
- R10: After reset, the accumulator and both stored codes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| idx | input | IDX_W | Register index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |

## Verification
The bench sweeps all 256 codes through both commands over several accumulator patterns. It uses patterns with bits set at both ends, so that it catches:
- a design that swaps the direction bit;
- a right move off by one place, such as 7 instead of 8 for code 0x08;
- a rotate that drops bits instead of wrapping them;
- an arithmetic right shift that copies the top bit instead of filling with zeros.

Codes with a high nibble but a zero low nibble expose a design that tests the whole byte for zero, or that lets the upper bits steer the move. Writes to unmapped indices, and reads with the strobe low, show whether stray accesses leak into the accumulator or onto the bus.

// File: rtl/acc_shift_unit.sv
module acc_shift_unit #(
  parameter int        IDX_W = 5,
  parameter logic [7:0] VERSION = 8'h10,
  parameter logic [7:0] SIGNATURE = 8'h51
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata
);
  localparam int W = 32;
  localparam int NBYTES = W / 8;
  localparam logic [IDX_W-1:0] IX_SHIFT = IDX_W'(NBYTES);
  localparam logic [IDX_W-1:0] IX_ROT   = IDX_W'(NBYTES + 1);
  localparam logic [IDX_W-1:0] IX_VER   = IDX_W'(5'h1E);
  localparam logic [IDX_W-1:0] IX_SIG   = IDX_W'(5'h1F);

  logic [W-1:0] acc;
  logic [7:0]   shift_code, rot_code;

  function automatic logic [W-1:0] apply(input logic [W-1:0] v, input logic [7:0] c, input logic rot);
    logic [4:0]     amt;
    logic [2*W-1:0] dbl, moved;
    amt = c[3] ? 5'd8 - {2'b0, c[2:0]} : {2'b0, c[2:0]};
    dbl = {v, v};
    if (c[3:0] == 4'd0) return v;
    if (c[3]) begin
      moved = dbl >> amt;
      return rot ? moved[W-1:0] : (v >> amt);
    end
    moved = dbl << amt;
    return rot ? moved[2*W-1:W] : (v << amt);
  endfunction

  wire wr_byte  = wr_en && (idx < IDX_W'(NBYTES));
  wire wr_shift = wr_en && (idx == IX_SHIFT);
  wire wr_rot   = wr_en && (idx == IX_ROT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc        <= '0;
      shift_code <= '0;
      rot_code   <= '0;
    end else begin
      if (wr_byte) begin
        for (int k = 0; k < NBYTES; k++)
          if (idx == IDX_W'(k)) acc[8*k +: 8] <= wdata;
      end
      if (wr_shift) begin
        shift_code <= wdata;
        acc        <= apply(acc, wdata, 1'b0);
      end
      if (wr_rot) begin
        rot_code <= wdata;
        acc      <= apply(acc, wdata, 1'b1);
      end
    end
  end

  logic [7:0] rmux;
  always_comb begin
    rmux = 8'h00;
    for (int k = 0; k < NBYTES; k++)
      if (idx == IDX_W'(k)) rmux = acc[8*k +: 8];
    if (idx == IX_SHIFT) rmux = shift_code;
    if (idx == IX_ROT)   rmux = rot_code;
    if (idx == IX_VER)   rmux = VERSION;
    if (idx == IX_SIG)   rmux = SIGNATURE;
  end

  assign rdata = rd_en ? rmux : 8'h00;
endmodule

// File: rtl/acc_shift_unit_chk.sv
module acc_shift_unit_chk #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic [IDX_W-1:0] idx,
  input logic [7:0]       wdata,
  input logic [7:0]       rdata,
  input logic [31:0]      acc
);
  // R1
  byte_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == IDX_W'(0)) |=> (acc[7:0] == $past(wdata) && acc[31:8] == $past(acc[31:8])));

  // R3
  left_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == IDX_W'(4) && !wdata[3]) |=> (acc == ($past(acc) << $past(wdata[2:0]))));

  // R5
  rotate_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == IDX_W'(5)) |=> ($countones(acc) == $countones($past(acc))));

  // R6
  zero_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (idx == IDX_W'(4) || idx == IDX_W'(5)) && wdata[3:0] == 4'd0) |=> $stable(acc));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(acc));

  // R9
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == 8'h00));

  // R8
  version_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && idx == IDX_W'(5'h1E)) |-> (rdata == 8'h10));
endmodule

bind acc_shift_unit acc_shift_unit_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
  .idx(idx), .wdata(wdata), .rdata(rdata), .acc(acc)
);

// File: tb/sim_acc_shift_unit.sv
module sim_acc_shift_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 150000;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_en = 0;
  logic       rd_en = 0;
  logic [4:0] idx = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  int total = 0;
  int bad = 0;
  bit done = 0;

  acc_shift_unit u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                     .idx(idx), .wdata(wdata), .rdata(rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] i, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; idx = i; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [4:0] i, output logic [7:0] d);
    rd_en = 1; idx = i;
    #1;
    d = rdata;
    rd_en = 0;
    #1;
  endtask

  task automatic load(input logic [31:0] v);
    for (int k = 0; k < 4; k++) wr(5'(k), v[8*k +: 8]);
  endtask

  task automatic read_acc(output logic [31:0] v);
    logic [7:0] b;
    for (int k = 0; k < 4; k++) begin
      rd(5'(k), b);
      v[8*k +: 8] = b;
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] v, input logic [7:0] c, input bit rot);
    int n;
    logic [31:0] r;
    r = v;
    if (c[3:0] == 0) return r;
    if (c[3]) begin
      n = 8 - int'(c[2:0]);
      for (int s = 0; s < n; s++) r = {rot ? r[0] : 1'b0, r[31:1]};
    end else begin
      n = int'(c[2:0]);
      for (int s = 0; s < n; s++) r = {r[30:0], rot ? r[31] : 1'b0};
    end
    return r;
  endfunction

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [31:0] pats[4];
    logic [31:0] v, got, exp;
    logic [7:0]  b;
    pats[0] = 32'h8000_0001;
    pats[1] = 32'hDEAD_BEEF;
    pats[2] = 32'h0F0F_3C5A;
    pats[3] = 32'hFFFF_FFFF;

    repeat (3) @(negedge clk);
    // R10
    read_acc(got); chk("R10 acc reset", got, 32'h0);
    rd(5'd4, b); chk("R10 shift code reset", {24'h0, b}, 32'h0);
    rd(5'd5, b); chk("R10 rotate code reset", {24'h0, b}, 32'h0);
    rst_n = 1;
    @(negedge clk);

    // R1
    load(32'h1234_5678);
    read_acc(got); chk("R1 byte load", got, 32'h1234_5678);
    wr(5'd2, 8'hA5);
    read_acc(got); chk("R1 single byte write", got, 32'h12A5_5678);

    // R8
    rd(5'h1E, b); chk("R8 version", {24'h0, b}, 32'h10);
    rd(5'h1F, b); chk("R8 signature", {24'h0, b}, 32'h51);

    // R9
    wr(5'd6, 8'hFF); wr(5'h10, 8'h77); wr(5'h1E, 8'h00);
    read_acc(got); chk("R9 unmapped write ignored", got, 32'h12A5_5678);
    rd(5'd6, b); chk("R9 unmapped read", {24'h0, b}, 32'h0);
    rd(5'h1E, b); chk("R9 version after write", {24'h0, b}, 32'h10);
    #1; chk("R9 rdata idle", {24'h0, rdata}, 32'h0);

    // R2 R3 R4 R5 R6 R7: sweep of all codes on both commands
    for (int p = 0; p < 4; p++) begin
      for (int op = 0; op < 2; op++) begin
        for (int c = 0; c < 256; c++) begin
          v = pats[p];
          load(v);
          wr(op ? 5'd5 : 5'd4, 8'(c));
          exp = model(v, 8'(c), op == 1);
          read_acc(got);
          if (op == 1) chk("R5 R6 R7 rotate result", got, exp);
          else if (c[3]) chk("R4 R6 R7 right shift result", got, exp);
          else chk("R3 R6 R7 left shift result", got, exp);
          rd(op ? 5'd5 : 5'd4, b);
          chk("R2 code readback", {24'h0, b}, 32'(c));
        end
      end
    end

    // R6 explicit corner cases
    load(32'hCAFE_F00D); wr(5'd5, 8'hF0);
    read_acc(got); chk("R6 rotate high-nibble-only code", got, 32'hCAFE_F00D);
    wr(5'd4, 8'h08);
    read_acc(got); chk("R4 right by 8", got, 32'h00CA_FEF0);
    load(32'h8000_0001); wr(5'd5, 8'h0F);
    read_acc(got); chk("R5 rotate right 1", got, 32'hC000_0000);

    finish_up();
  end
endmodule